// File: doc/BRIEF.md
# Exponent-prescaled I2C SCL clock generator

This block derives the SCL high and low phase timing for an I2C master engine from the system clock. A single 19-bit waveform word sets a low-phase divider, a high-phase divider and a power-of-two prescale exponent. Each phase lasts the divider shifted left by the exponent, plus a fixed offset of system clocks (the `OFFSET` parameter, typically 3 or 4). For symmetric settings the resulting SCL rate is f_sys / (2 * (div * 2^exp + OFFSET)). Normal targets are 100 kHz, with up to 400 kHz supported. The exponent is limited by the `EXP_MAX` parameter, typically 5 or 7.

The block drives a level `scl_o`, where 1 means SCL is released, and two single-cycle markers: `fall_tick` on the first cycle of each low phase and `rise_tick` on the first cycle of each high phase. The master engine uses these to time its bus actions.

A three-state machine controls the output:
- IDLE: disabled, SCL released, counter cleared.
- LOW: SCL driven low.
- HIGH: SCL released.

The transitions are:
- start (IDLE to LOW when enabled).
- release (LOW to HIGH when the low count expires).
- pull (HIGH to LOW when the high count expires).
- halt (LOW or HIGH to IDLE when the enable drops).

The length of each phase is computed from the waveform word present at the clock edge that starts the phase.

Top module: `sclk_gen`

## Requirements
- R1: The waveform word holds the low-phase divider in bits 7:0, the high-phase divider in bits 15:8 and the exponent in bits 18:16.
- R2: A low phase (`scl_o` = 0) lasts exactly low_div * 2^exp + OFFSET system clocks.
- R3: A high phase (`scl_o` = 1 while enabled) lasts exactly high_div * 2^exp + OFFSET system clocks.
- R4: An exponent field greater than EXP_MAX is treated as EXP_MAX, with both dividers taken as 255.
- R5: From the cycle after `enable` is sampled low, `scl_o` is 1, both ticks are 0 and the phase count is cleared.
- R6: From IDLE, the cycle after `enable` is sampled high starts a full-length low phase, marked by `fall_tick`.
- R7: A change of the waveform word does not alter the phase in progress. The word present at the edge that ends a phase sets the length of the next phase.
- R8: `fall_tick` is 1 only on the first cycle of a low phase, and `rise_tick` only on the first cycle of a high phase. The two are never 1 together.
- R9: When `enable` drops in the cycle in which a phase ends, the block goes to IDLE and no new phase or tick follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low forces IDLE |
| cfg_word | input | 19 | Waveform word: low divider, high divider, exponent |
| scl_o | output | 1 | SCL level, 1 = released |
| fall_tick | output | 1 | First cycle of a low phase |
| rise_tick | output | 1 | First cycle of a high phase |

## Verification
Two events can fall in the same cycle as a phase boundary: a rewrite of the waveform word and a drop of `enable`. The bench counts low cycles as they are observed. It rewrites the high divider on exactly the last low cycle and expects the following high phase to use the new value. In a separate run it drops `enable` on the last low cycle and expects SCL to be released, with no `rise_tick` and no further phase. A rewrite placed in the middle of a phase is also checked: the current phase keeps its length and only the next phase changes.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    localparam int DIV_W   = 8;
    localparam int EXP_W   = 3;
    localparam int CFG_W   = 2 * DIV_W + EXP_W;
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = DIV_W;
    localparam int EXP_LSB = 2 * DIV_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_st_t;
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
    import sclk_pkg::*;
#(
    parameter int EXP_MAX = 7
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [DIV_W-1:0] lo_div,
    output logic [DIV_W-1:0] hi_div,
    output logic [EXP_W-1:0] exp_eff
);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);
    localparam logic [DIV_W-1:0] DIV_SAT = {DIV_W{1'b1}};

    logic [DIV_W-1:0] lo_raw;
    logic [DIV_W-1:0] hi_raw;
    logic [EXP_W-1:0] exp_raw;
    logic             over;

    assign lo_raw  = cfg_word[LO_LSB  +: DIV_W];
    assign hi_raw  = cfg_word[HI_LSB  +: DIV_W];
    assign exp_raw = cfg_word[EXP_LSB +: EXP_W];
    assign over    = (exp_raw > EXP_CAP);

    always_comb begin
        if (over) begin
            exp_eff = EXP_CAP;
            lo_div  = DIV_SAT;
            hi_div  = DIV_SAT;
        end else begin
            exp_eff = exp_raw;
            lo_div  = lo_raw;
            hi_div  = hi_raw;
        end
    end
endmodule

// File: rtl/sclk_phase_len.sv
module sclk_phase_len
    import sclk_pkg::*;
#(
    parameter int OFFSET = 4,
    parameter int LEN_W  = 16
) (
    input  logic [DIV_W-1:0] div,
    input  logic [EXP_W-1:0] expo,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] stg [0:EXP_W];

    assign stg[0] = LEN_W'(div);

    for (genvar i = 0; i < EXP_W; i++) begin : g_shift
        assign stg[i+1] = expo[i] ? (stg[i] << (1 << i)) : stg[i];
    end

    assign len = stg[EXP_W] + LEN_W'(OFFSET);
endmodule

// File: rtl/sclk_phase_counter.sv
module sclk_phase_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - LEN_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
#(
    parameter int OFFSET  = 4,
    parameter int EXP_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             scl_o,
    output logic             fall_tick,
    output logic             rise_tick
);
    localparam int LEN_W = DIV_W + EXP_MAX + 1;

    phase_st_t        state_q, state_d;
    logic             first_q, first_d;
    logic             ld, clr, sel_high;
    logic             phase_last;
    logic [DIV_W-1:0] lo_div, hi_div;
    logic [EXP_W-1:0] exp_eff;
    logic [LEN_W-1:0] lo_len, hi_len, ld_len;

    sclk_cfg_decode #(.EXP_MAX(EXP_MAX)) u_dec (
        .cfg_word (cfg_word),
        .lo_div   (lo_div),
        .hi_div   (hi_div),
        .exp_eff  (exp_eff)
    );

    sclk_phase_len #(.OFFSET(OFFSET), .LEN_W(LEN_W)) u_lo_len (
        .div  (lo_div),
        .expo (exp_eff),
        .len  (lo_len)
    );

    sclk_phase_len #(.OFFSET(OFFSET), .LEN_W(LEN_W)) u_hi_len (
        .div  (hi_div),
        .expo (exp_eff),
        .len  (hi_len)
    );

    assign ld_len = sel_high ? hi_len : lo_len;

    sclk_phase_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (ld),
        .load_len (ld_len),
        .last     (phase_last)
    );

    // transitions: start, release, pull, halt
    always_comb begin
        state_d  = state_q;
        first_d  = 1'b0;
        ld       = 1'b0;
        clr      = 1'b0;
        sel_high = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_d = ST_LOW;
                    ld      = 1'b1;
                    first_d = 1'b1;
                end else begin
                    clr = 1'b1;
                end
            end
            ST_LOW: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end else if (phase_last) begin
                    state_d  = ST_HIGH;
                    ld       = 1'b1;
                    sel_high = 1'b1;
                    first_d  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end else if (phase_last) begin
                    state_d = ST_LOW;
                    ld      = 1'b1;
                    first_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                clr     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
        end
    end

    always_comb begin
        scl_o     = (state_q != ST_LOW);
        fall_tick = (state_q == ST_LOW)  && first_q;
        rise_tick = (state_q == ST_HIGH) && first_q;
    end
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
    import sclk_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      enable,
    input logic      scl_o,
    input logic      fall_tick,
    input logic      rise_tick,
    input phase_st_t state_q,
    input logic      phase_last
);
    assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !fall_tick && !rise_tick));

    assert_ticks_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_tick, rise_tick}));

    assert_fall_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> fall_tick);

    assert_rise_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> (rise_tick || !$past(enable)));

    assert_restart_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_IDLE) |=> (fall_tick && !scl_o));

    assert_low_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_LOW && !phase_last) |=> (!scl_o && !fall_tick));

    assert_high_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_HIGH && !phase_last) |=> (scl_o && !rise_tick));

    assert_halt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && phase_last && state_q != ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

bind sclk_gen sclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_o      (scl_o),
    .fall_tick  (fall_tick),
    .rise_tick  (rise_tick),
    .state_q    (state_q),
    .phase_last (phase_last)
);

// File: tb/tb_sclk_gen.sv
module tb_sclk_gen;
    localparam int OFF  = 3;
    localparam int EMAX = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [18:0] cfg_word = '0;
    logic        scl_o, fall_tick, rise_tick;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sclk_gen #(.OFFSET(OFF), .EXP_MAX(EMAX)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_word  (cfg_word),
        .scl_o     (scl_o),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );

    function automatic int exp_len(int d, int e);
        if (e > EMAX) return (255 << EMAX) + OFF;
        return (d << e) + OFF;
    endfunction

    function automatic logic [18:0] mk(int lo, int hi, int e);
        return {3'(e), 8'(hi), 8'(lo)};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_level(logic lvl, output int n);
        n = 0;
        while (scl_o == lvl && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_cfg(int lo, int hi, int e);
        @(negedge clk);
        enable = 1'b0;
        cfg_word = mk(lo, hi, e);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic sweep_one(int lo, int hi, int e);
        int n;
        start_cfg(lo, hi, e);
        chk(fall_tick && !scl_o, "R6 fall_tick on restart", int'(fall_tick), 1);
        count_level(1'b0, n);
        chk(n == exp_len(lo, e), (e > EMAX) ? "R4 clamped low length" : "R2/R1 low length", n, exp_len(lo, e));
        chk(rise_tick && !fall_tick, "R8 rise_tick at high start", int'(rise_tick), 1);
        count_level(1'b1, n);
        chk(n == exp_len(hi, e), (e > EMAX) ? "R4 clamped high length" : "R3/R1 high length", n, exp_len(hi, e));
        chk(fall_tick && !rise_tick, "R8 fall_tick at next low", int'(fall_tick), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int los[4] = '{0, 1, 5, 255};
        int his[3] = '{0, 3, 128};

        repeat (3) @(negedge clk);
        chk(scl_o && !fall_tick && !rise_tick, "R5 reset state released", int'(scl_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o, "R5 idle after reset", int'(scl_o), 1);

        for (int e = 0; e <= EMAX + 1; e++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 3; b++)
                    sweep_one(los[a], his[b], e);
        sweep_one(1, 1, 7);

        // R7: mid-phase rewrite keeps current phase
        start_cfg(10, 4, 0);
        n = 0;
        while (scl_o == 1'b0 && n < 1000) begin
            n++;
            if (n == 4) cfg_word = mk(2, 4, 0);
            @(negedge clk);
        end
        chk(n == 13, "R7 low phase unchanged by mid rewrite", n, 13);
        count_level(1'b1, n);
        chk(n == 7, "R7 high phase", n, 7);
        count_level(1'b0, n);
        chk(n == 5, "R7 next low uses new word", n, 5);

        // R7: rewrite on the last low cycle sets the next high phase
        start_cfg(6, 1, 1);
        n = 0;
        while (scl_o == 1'b0 && n < 1000) begin
            n++;
            if (n == 15) cfg_word = mk(6, 9, 1);
            @(negedge clk);
        end
        chk(n == 15, "R7 low before boundary rewrite", n, 15);
        count_level(1'b1, n);
        chk(n == 21, "R7 boundary rewrite applies to high", n, 21);

        // R9: disable on the last low cycle
        start_cfg(2, 2, 0);
        n = 0;
        while (scl_o == 1'b0 && n < 1000) begin
            n++;
            if (n == 5) enable = 1'b0;
            @(negedge clk);
        end
        chk(n == 5, "R9 low length before halt", n, 5);
        chk(scl_o && !rise_tick && !fall_tick, "R9 halt wins over boundary", int'(rise_tick), 0);
        repeat (3) @(negedge clk);
        chk(scl_o && !rise_tick && !fall_tick, "R5 stays idle", int'(scl_o), 1);
        enable = 1'b1;
        @(negedge clk);
        chk(fall_tick, "R6 restart after halt", int'(fall_tick), 1);
        count_level(1'b0, n);
        chk(n == 5, "R6 full low after restart", n, 5);

        // R5: disable in mid high phase
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_o && !fall_tick, "R5 mid-phase disable", int'(fall_tick), 0);
        enable = 1'b1;
        @(negedge clk);
        chk(fall_tick && !scl_o, "R5 counter cleared, R6 fresh low", int'(scl_o), 0);
        count_level(1'b0, n);
        chk(n == 5, "R5 fresh low length", n, 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule